// File: doc/BRIEF.md
# Cascadable Serial Relay-Output Controller

This block turns a three-wire serial stream into eight relay control levels. A host drives chip select low, presents data bits one at a time and pulses the serial clock; each rising clock edge pushes the data bit into an eight-stage shift register, most significant bit first. When chip select is released, the shifted word is copied into the output register, and all eight relay outputs change together. Output bit 0 follows data bit D0, output bit 7 follows D7.

A serial data output carries the bit leaving the last shift stage. It changes on the falling serial clock edge, so a downstream device sampling on the next rising edge has hold margin. Several controllers can then be chained into one long shift path. They can also share one data line with separate chip selects, so that only the selected device accepts a word. Two active-low override inputs force every output on (set) or off (clear). Clear wins when both are asserted. The overrides reach the outputs at once, load the output register, and leave the shift register alone.

All serial and override pins are treated as asynchronous to the system clock `clk_i`. They are resynchronised before use. The override path to the outputs is combinational.

Top module: `relay_ser_ctrl`

## Requirements
- R1: While `cs_ni` is low, each rising edge of `sclk_i` shifts `din_i` into the shift register, first bit sent ending in the top stage (D7 first); after eight edges and a chip-select release, `relay_o` equals the word sent, with `relay_o[i]` driven by data bit Di.
- R2: `relay_o` changes only on a rising edge of `cs_ni` (or through an override). Between such edges it keeps its value while bits are being shifted. On that edge all eight bits take the shift register contents together.
- R3: While `cs_ni` is high, `sclk_i` edges are ignored and the shift register holds its value, so a later chip-select pulse with no clocks latches the previously shifted word.
- R4: Driving `clr_ni` low forces `relay_o` to all zeros without waiting for a clock, and the output register stays zero after `clr_ni` returns high.
- R5: Driving `set_ni` low while `clr_ni` is high forces `relay_o` to all ones without waiting for a clock, and the output register stays all ones after release.
- R6: With `set_ni` and `clr_ni` both low, `relay_o` is all zeros.
- R7: The set and clear overrides do not alter the shift register contents.
- R8: `dout_o` presents the top shift stage and updates only on falling edges of `sclk_i`; after 8+j rising edges within one select window, `dout_o` shows the j-th bit sent (counting from 0).
- R9: After `rst_ni` is released, `relay_o` and `dout_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample all serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select; rising edge latches the word |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data in |
| set_ni | input | 1 | Active-low force-all-on |
| clr_ni | input | 1 | Active-low force-all-off, dominates set |
| dout_o | output | 1 | Serial data out for chaining |
| relay_o | output | N_OUT | Relay control levels, bit i driven by data bit Di |

## Verification
The assertions check the following on every cycle:
- The shift register and the output register stay unchanged whenever no qualified serial clock edge or latch strobe occurs.
- A latch strobe copies the shift word.
- The synchronised overrides load zeros or ones, with clear dominating.
- `dout_o` moves only on a falling serial clock edge, and then to the top stage.

The bench scenarios show the rest:
- Bit order and output mapping end to end.
- The immediate, clock-free effect of the overrides at the pins.
- That overrides leave a previously shifted word intact.
- The chained stream timing, where `dout_o` replays the first byte during the second.

// File: rtl/relay_pkg.sv
package relay_pkg;
  typedef struct packed {
    logic sclk;
    logic cs_n;
    logic din;
    logic set_n;
    logic clr_n;
  } pin_vec_t;

  localparam int PIN_W = $bits(pin_vec_t);
  localparam pin_vec_t PIN_IDLE = '{sclk: 1'b0, cs_n: 1'b1, din: 1'b0, set_n: 1'b1, clr_n: 1'b1};
endpackage

// File: rtl/relay_sync.sv
module relay_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/relay_edge.sv
module relay_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_rise_o
);
  logic sclk_d, cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_i;
      cs_d   <= cs_ni;
    end
  end

  assign sclk_rise_o = sclk_i & ~sclk_d;
  assign sclk_fall_o = ~sclk_i & sclk_d;
  assign cs_rise_o   = cs_ni & ~cs_d;
endmodule

// File: rtl/relay_shift.sv
module relay_shift #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_rise_i,
  input  logic         sclk_fall_i,
  input  logic         cs_ni,
  input  logic         din_i,
  output logic [N-1:0] shift_q_o,
  output logic         shift_en_o,
  output logic         dout_o
);
  logic [N-1:0] sr_q;
  logic         dout_q;

  assign shift_en_o = sclk_rise_i & ~cs_ni;

  // MSB first: first bit ends in the top stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_o) sr_q <= {sr_q[N-2:0], din_i};
  end

  // falling-edge launch gives hold to the next device
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          dout_q <= 1'b0;
    else if (sclk_fall_i) dout_q <= sr_q[N-1];
  end

  assign shift_q_o = sr_q;
  assign dout_o    = dout_q;
endmodule

// File: rtl/relay_outreg.sv
module relay_outreg #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] word_i,
  input  logic         set_s_i,
  input  logic         clr_s_i,
  input  logic         set_ni,
  input  logic         clr_ni,
  output logic [N-1:0] latch_q_o,
  output logic [N-1:0] out_o
);
  logic [N-1:0] lat_q;

  // priority: clear > set > latch strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lat_q <= '0;
    else if (!clr_s_i) lat_q <= '0;
    else if (!set_s_i) lat_q <= '1;
    else if (load_i)   lat_q <= word_i;
  end

  // raw pins give the clock-free override at the outputs
  always_comb begin
    if (!clr_ni)      out_o = '0;
    else if (!set_ni) out_o = '1;
    else              out_o = lat_q;
  end

  assign latch_q_o = lat_q;
endmodule

// File: rtl/relay_ser_ctrl.sv
module relay_ser_ctrl #(
  parameter int N_OUT = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             din_i,
  input  logic             set_ni,
  input  logic             clr_ni,
  output logic             dout_o,
  output logic [N_OUT-1:0] relay_o
);
  import relay_pkg::*;

  pin_vec_t   pin_raw, pin_s;
  logic       sclk_rise, sclk_fall, load, shift_en;
  logic [N_OUT-1:0] shift_q, latch_q;

  assign pin_raw = '{sclk: sclk_i, cs_n: cs_ni, din: din_i, set_n: set_ni, clr_n: clr_ni};

  relay_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (pin_raw), .q_o (pin_s)
  );

  relay_edge u_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .sclk_i (pin_s.sclk), .cs_ni (pin_s.cs_n),
    .sclk_rise_o (sclk_rise), .sclk_fall_o (sclk_fall), .cs_rise_o (load)
  );

  relay_shift #(.N(N_OUT)) u_shift (
    .clk_i (clk_i), .rst_ni (rst_ni), .sclk_rise_i (sclk_rise), .sclk_fall_i (sclk_fall),
    .cs_ni (pin_s.cs_n), .din_i (pin_s.din), .shift_q_o (shift_q),
    .shift_en_o (shift_en), .dout_o (dout_o)
  );

  relay_outreg #(.N(N_OUT)) u_out (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (load), .word_i (shift_q),
    .set_s_i (pin_s.set_n), .clr_s_i (pin_s.clr_n), .set_ni (set_ni), .clr_ni (clr_ni),
    .latch_q_o (latch_q), .out_o (relay_o)
  );
endmodule

// File: rtl/relay_ser_chk.sv
module relay_ser_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         set_s,
  input logic         clr_s,
  input logic         load,
  input logic         shift_en,
  input logic         sclk_fall,
  input logic [N-1:0] shift_q,
  input logic [N-1:0] latch_q,
  input logic         dout_o
);
  // R3
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en |=> $stable(shift_q));
  // R2
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && set_s && clr_s) |=> $stable(latch_q));
  // R2
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && set_s && clr_s) |=> latch_q == $past(shift_q));
  // R4
  clr_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_s |=> latch_q == '0);
  // R5
  set_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_s && !set_s) |=> latch_q == '1);
  // R7
  ovr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!clr_s || !set_s) && !shift_en) |=> $stable(shift_q));
  // R8
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall |=> $stable(dout_o));
  // R8
  dout_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall |=> dout_o == $past(shift_q[N-1]));
endmodule

bind relay_ser_ctrl relay_ser_chk #(.N(N_OUT)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .set_s (pin_s.set_n), .clr_s (pin_s.clr_n),
  .load (load), .shift_en (shift_en), .sclk_fall (sclk_fall), .shift_q (shift_q),
  .latch_q (latch_q), .dout_o (dout_o)
);

// File: tb/sim_relay_ser_ctrl.sv
module sim_relay_ser_ctrl;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, set_n = 1'b1, clr_n = 1'b1;
  logic dout;
  logic [7:0] relay;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model_sr = '0;
  logic [7:0] exp_out = '0;
  logic [15:0] stream;

  always #4 clk = ~clk;

  relay_ser_ctrl u0 (
    .clk_i (clk), .rst_ni (rst_n), .cs_ni (cs_n), .sclk_i (sclk), .din_i (din),
    .set_ni (set_n), .clr_ni (clr_n), .dout_o (dout), .relay_o (relay)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit; checks R8 dout at end of high phase (old) and low phase (new)
  task automatic send_bit(input logic b);
    logic prev_top;
    din = b;
    wait_cyc(P);
    prev_top = model_sr[7];
    sclk = 1'b1;
    wait_cyc(P);
    chk("R8 dout held across rise", {7'd0, dout}, {7'd0, prev_top});
    if (!cs_n) model_sr = {model_sr[6:0], b};
    sclk = 1'b0;
    wait_cyc(P);
    chk("R8 dout after fall", {7'd0, dout}, {7'd0, model_sr[7]});
  endtask

  task automatic release_cs();
    cs_n = 1'b1;
    wait_cyc(2 * P);
    exp_out = model_sr;
  endtask

  task automatic send_word(input logic [7:0] w);
    cs_n = 1'b0;
    wait_cyc(P);
    for (int i = 7; i >= 0; i--) send_bit(w[i]);
    chk("R2 outputs wait for cs rise", relay, exp_out);
    release_cs();
    chk("R1 latched word", relay, w);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    // R9
    chk("R9 reset outputs", relay, 8'h00);
    chk("R9 reset dout", {7'd0, dout}, 8'h00);

    // R1 mapping: D0 -> bit 0, D7 -> bit 7
    send_word(8'h01);
    chk("R1 only lowest output", relay, 8'h01);
    send_word(8'h80);
    send_word(8'ha5);
    for (int k = 0; k < 24; k++) send_word(8'($urandom()));

    // R3: clocks with cs high are ignored
    for (int k = 0; k < 5; k++) send_bit(1'($urandom()));
    chk("R3 outputs steady while deselected", relay, exp_out);
    cs_n = 1'b0;
    wait_cyc(P);
    release_cs();
    chk("R3 shift register held while deselected", relay, model_sr);

    // R5 set alone
    set_n = 1'b0;
    wait_cyc(1);
    chk("R5 set forces ones", relay, 8'hff);
    wait_cyc(8);
    set_n = 1'b1;
    wait_cyc(P);
    chk("R5 ones held after set release", relay, 8'hff);

    // R4 clear
    clr_n = 1'b0;
    wait_cyc(1);
    chk("R4 clear forces zeros", relay, 8'h00);
    wait_cyc(8);
    clr_n = 1'b1;
    wait_cyc(P);
    chk("R4 zeros held after clear release", relay, 8'h00);

    // R6 both asserted
    set_n = 1'b0;
    clr_n = 1'b0;
    wait_cyc(8);
    chk("R6 clear dominates set", relay, 8'h00);
    clr_n = 1'b1;
    wait_cyc(1);
    chk("R6 set visible once clear drops", relay, 8'hff);
    wait_cyc(8);
    set_n = 1'b1;
    wait_cyc(P);
    chk("R5 ones held after overlap", relay, 8'hff);

    // R7 shift register untouched by overrides
    cs_n = 1'b0;
    wait_cyc(P);
    release_cs();
    chk("R7 shift word survives overrides", relay, model_sr);

    // R8 chained stream: dout replays first byte during second
    stream = 16'($urandom());
    cs_n = 1'b0;
    wait_cyc(P);
    for (int k = 1; k <= 16; k++) begin
      send_bit(stream[16 - k]);
      if (k >= 8) chk("R8 chain dout bit", {7'd0, dout}, {7'd0, stream[15 - (k - 8)]});
    end
    release_cs();
    chk("R1 chain tail byte latched", relay, stream[7:0]);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule